// File: doc/BRIEF.md
# Nested-loop DMA transfer engine

This block is a single-channel data mover that runs from a transfer descriptor. Software writes the descriptor fields on a parallel configuration port and strobes a load pulse. The fields are the source and destination addresses, a signed step for each side, the inner byte count, the outer iteration count, and the interrupt, error and link options. Every word moved is a read at the current source address followed by a write of that data to the current destination address. The engine issues both over a single-outstanding memory request/response port.

The engine has two nested loops. One activation runs exactly one inner loop, which moves the programmed number of bytes as whole words. Each inner loop that finishes takes one off the outer iteration count. An activation may come from a software start, from another channel's link, or from a peripheral request. When the outer count reaches zero, the engine sets a sticky done bit and can raise a completion interrupt. When an inner loop finishes and more outer iterations remain, the engine can pulse a link request that names a target channel. A cancel input stops a transfer in progress. A memory error response halts the channel.

Top module: `nlx_dma_engine`

## Requirements
- R1: A `cfg_load` pulse while idle latches every descriptor field. On the next cycle `cur_src`, `cur_dst` and `major_left` show the loaded values, and `done`, `irq_major` and `irq_err` are clear. A `cfg_load` while busy is ignored. When `cfg_load` and an activation arrive in the same cycle, the load wins and the activation is dropped.
- R2: A one-cycle pulse on any of `sw_start`, `link_in` or `hw_req` starts one inner loop, but only while idle, with `major_left` nonzero and the channel not halted by an error. Activations that arrive while busy, with `major_left` at zero or while halted have no effect.
- R3: Each word is moved as a read (`mem_we`=0) at `cur_src` and then a write (`mem_we`=1) at `cur_dst` that carries the read data. A request stays asserted with a stable address until a cycle in which `mem_rvalid` is 1.
- R4: After each accepted write, `cur_src` advances by the signed `cfg_soff` and `cur_dst` advances by the signed `cfg_doff`, modulo 2^AW. The addresses carry on across inner loops.
- R5: An inner loop moves `cfg_nbytes` divided by the word size (4 bytes, remainder dropped) words. A count below one word moves one word. The engine then returns to idle, and `major_left` drops by exactly one.
- R6: When `cfg_link_en` is set, every inner loop that leaves `major_left` nonzero is followed by a `link_req` pulse of exactly one cycle, with `link_ch` equal to the programmed `cfg_link_ch`. The inner loop that takes `major_left` to zero gives no pulse.
- R7: `done` is set when `major_left` reaches zero. `irq_major` is `done` gated by the programmed interrupt enable. Both clear on `done_clr` or on a descriptor load.
- R8: Raising `cancel` while busy returns the engine to idle, and `mem_req` is low from the next cycle on. `major_left` is unchanged. The addresses keep the values they had after the last completed word.
- R9: A response with `mem_err`=1 halts the engine without advancing the addresses or `major_left`. `irq_err` rises if `cfg_err_en` was set. Later activations are ignored until the next descriptor load.
- R10: After reset the engine is idle with `mem_req`, `done`, `irq_major`, `irq_err` and `link_req` low, and with `major_left`, `cur_src` and `cur_dst` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Latch the descriptor fields (only while idle) |
| cfg_src | input | AW | Starting source byte address |
| cfg_dst | input | AW | Starting destination byte address |
| cfg_soff | input | OW | Signed source step per word |
| cfg_doff | input | OW | Signed destination step per word |
| cfg_nbytes | input | NBW | Bytes per inner loop |
| cfg_major | input | CW | Outer iteration count |
| cfg_int_en | input | 1 | Enable the completion interrupt |
| cfg_err_en | input | 1 | Enable the error interrupt |
| cfg_link_en | input | 1 | Enable link pulses between inner loops |
| cfg_link_ch | input | LCW | Channel number sent with each link pulse |
| sw_start | input | 1 | Software activation |
| link_in | input | 1 | Activation from another channel's link |
| hw_req | input | 1 | Peripheral activation |
| cancel | input | 1 | Abort the transfer in progress |
| done_clr | input | 1 | Clear the done bit |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Response for the current request |
| mem_rdata | input | DW | Read data |
| mem_err | input | 1 | Response carries an error |
| busy | output | 1 | An inner loop is in progress |
| done | output | 1 | Outer count has expired (sticky) |
| irq_major | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |
| link_req | output | 1 | One-cycle link pulse |
| link_ch | output | LCW | Target channel of the link |
| major_left | output | CW | Remaining outer iterations |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |

## Verification
The assertions assume that the memory side never raises `mem_rvalid` or `mem_err` for more than one cycle per request, and that a response arriving while `mem_req` is low carries no meaning. The bench memory model replies on alternate cycles only and only to an active request. The checks on request holding and on a write following a read therefore rely on a well-formed responder. The stimulus applies `cancel` and activations for single cycles and waits for idle before it loads a new descriptor. The only exception is the one test that deliberately loads and re-activates while busy.

// File: rtl/nlx_dma_pkg.sv
package nlx_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  // Words per inner loop: byte count shifted down by log2(word bytes),
  // never less than one.
  function automatic int unsigned minor_words(input int unsigned nbytes,
                                              input int unsigned wb_log2);
    int unsigned w;
    w = nbytes >> wb_log2;
    return (w == 0) ? 1 : w;
  endfunction

endpackage

// File: rtl/nlx_dma_addr_gen.sv
module nlx_dma_addr_gen #(
  parameter int AW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [OW-1:0] soff_init,
  input  logic [OW-1:0] doff_init,
  input  logic          step,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst
);

  logic [OW-1:0] soff_q, doff_q;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic [OW-1:0] off);
    return a + AW'($signed(off));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src    <= '0;
      dst    <= '0;
      soff_q <= '0;
      doff_q <= '0;
    end else if (load) begin
      src    <= src_init;
      dst    <= dst_init;
      soff_q <= soff_init;
      doff_q <= doff_init;
    end else if (step) begin
      src <= step_addr(src, soff_q);
      dst <= step_addr(dst, doff_q);
    end
  end

endmodule

// File: rtl/nlx_dma_loop_ctr.sv
module nlx_dma_loop_ctr #(
  parameter int NBW = 8,
  parameter int CW  = 8,
  parameter int WBL = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NBW-1:0] nbytes_init,
  input  logic [CW-1:0]  major_init,
  input  logic           minor_start,
  input  logic           word_done,
  input  logic           minor_done,
  output logic           last_word,
  output logic           last_major,
  output logic [CW-1:0]  major_left
);

  logic [NBW-1:0] nwords_q, words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nwords_q   <= '0;
      words_q    <= '0;
      major_left <= '0;
    end else begin
      if (load) begin
        nwords_q   <= NBW'(nlx_dma_pkg::minor_words(32'(nbytes_init), WBL));
        major_left <= major_init;
      end else if (minor_done) begin
        major_left <= major_left - CW'(1);
      end
      if (minor_start)
        words_q <= nwords_q;
      else if (word_done)
        words_q <= words_q - NBW'(1);
    end
  end

  assign last_word  = (words_q == NBW'(1));
  assign last_major = (major_left == CW'(1));

endmodule

// File: rtl/nlx_dma_engine.sv
module nlx_dma_engine #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int OW  = 16,
  parameter int NBW = 8,
  parameter int CW  = 8,
  parameter int LCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [OW-1:0]  cfg_soff,
  input  logic [OW-1:0]  cfg_doff,
  input  logic [NBW-1:0] cfg_nbytes,
  input  logic [CW-1:0]  cfg_major,
  input  logic           cfg_int_en,
  input  logic           cfg_err_en,
  input  logic           cfg_link_en,
  input  logic [LCW-1:0] cfg_link_ch,
  input  logic           sw_start,
  input  logic           link_in,
  input  logic           hw_req,
  input  logic           cancel,
  input  logic           done_clr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_err,
  output logic           busy,
  output logic           done,
  output logic           irq_major,
  output logic           irq_err,
  output logic           link_req,
  output logic [LCW-1:0] link_ch,
  output logic [CW-1:0]  major_left,
  output logic [AW-1:0]  cur_src,
  output logic [AW-1:0]  cur_dst
);

  import nlx_dma_pkg::*;

  localparam int WB  = DW / 8;
  localparam int WBL = $clog2(WB);

  xfer_state_e    state_q, state_d;
  logic [DW-1:0]  rbuf_q;
  logic           halted_q, int_en_q, err_en_q, link_en_q;
  logic [LCW-1:0] link_ch_q;

  // Named internal events, also used by the checker.
  logic desc_load, activate, rsp, rd_ok, wr_ok, xfer_err, kill;
  logic minor_done, major_done, last_word, last_major;

  assign busy       = (state_q != ST_IDLE);
  assign desc_load  = cfg_load && !busy;
  assign activate   = (sw_start || link_in || hw_req) && !busy && !cfg_load
                      && (major_left != '0) && !halted_q;
  assign rsp        = mem_rvalid && busy;
  assign kill       = cancel && busy;
  assign rd_ok      = (state_q == ST_READ)  && rsp && !mem_err && !cancel;
  assign wr_ok      = (state_q == ST_WRITE) && rsp && !mem_err && !cancel;
  assign xfer_err   = rsp && mem_err && !cancel;
  assign minor_done = wr_ok && last_word;
  assign major_done = minor_done && last_major;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (activate) state_d = ST_READ;
      ST_READ:  if (kill || xfer_err) state_d = ST_IDLE;
                else if (rd_ok) state_d = ST_WRITE;
      ST_WRITE: if (kill || xfer_err) state_d = ST_IDLE;
                else if (wr_ok) state_d = last_word ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rbuf_q    <= '0;
      done      <= 1'b0;
      halted_q  <= 1'b0;
      int_en_q  <= 1'b0;
      err_en_q  <= 1'b0;
      link_en_q <= 1'b0;
      link_ch_q <= '0;
      link_req  <= 1'b0;
    end else begin
      state_q  <= state_d;
      link_req <= minor_done && !last_major && link_en_q;
      if (rd_ok) rbuf_q <= mem_rdata;
      if (desc_load) begin
        int_en_q  <= cfg_int_en;
        err_en_q  <= cfg_err_en;
        link_en_q <= cfg_link_en;
        link_ch_q <= cfg_link_ch;
        done      <= 1'b0;
        halted_q  <= 1'b0;
      end else begin
        if (major_done)    done <= 1'b1;
        else if (done_clr) done <= 1'b0;
        if (xfer_err) halted_q <= 1'b1;
      end
    end
  end

  nlx_dma_addr_gen #(.AW(AW), .OW(OW)) addr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (desc_load),
    .src_init  (cfg_src),
    .dst_init  (cfg_dst),
    .soff_init (cfg_soff),
    .doff_init (cfg_doff),
    .step      (wr_ok),
    .src       (cur_src),
    .dst       (cur_dst)
  );

  nlx_dma_loop_ctr #(.NBW(NBW), .CW(CW), .WBL(WBL)) loop_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (desc_load),
    .nbytes_init (cfg_nbytes),
    .major_init  (cfg_major),
    .minor_start (activate),
    .word_done   (wr_ok),
    .minor_done  (minor_done),
    .last_word   (last_word),
    .last_major  (last_major),
    .major_left  (major_left)
  );

  assign mem_req   = busy;
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = mem_we ? cur_dst : cur_src;
  assign mem_wdata = rbuf_q;
  assign irq_major = done && int_en_q;
  assign irq_err   = halted_q && err_en_q;
  assign link_ch   = link_ch_q;

endmodule

// File: rtl/nlx_dma_checker.sv
module nlx_dma_checker #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          mem_err,
  input logic          cancel,
  input logic          busy,
  input logic          minor_done,
  input logic [CW-1:0] major_left,
  input logic          link_req,
  input logic          irq_major,
  input logic          done
);

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && !cancel) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !$past(mem_we)) |->
      $past(mem_req && !mem_we && mem_rvalid && !mem_err));

  a_r5_major_step: assert property (@(posedge clk) disable iff (!rst_n)
    minor_done |=> (major_left == $past(major_left) - CW'(1)));

  a_r2_no_start_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && major_left == '0) |=> !busy);

  a_r6_link_single: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |=> !link_req);

  a_r6_link_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |-> (major_left != '0));

  a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_major |-> done);

  a_r8_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && busy) |=> !mem_req);

  a_r9_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && mem_err && !cancel) |=> !busy);

endmodule

bind nlx_dma_engine nlx_dma_checker #(.AW(AW), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .mem_err    (mem_err),
  .cancel     (cancel),
  .busy       (busy),
  .minor_done (minor_done),
  .major_left (major_left),
  .link_req   (link_req),
  .irq_major  (irq_major),
  .done       (done)
);

// File: tb/nlx_dma_engine_tb_top.sv
module nlx_dma_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_soff = '0, cfg_doff = '0;
  logic [7:0]  cfg_nbytes = '0, cfg_major = '0;
  logic        cfg_int_en = 1'b0, cfg_err_en = 1'b0, cfg_link_en = 1'b0;
  logic [3:0]  cfg_link_ch = '0;
  logic        sw_start = 1'b0, link_in = 1'b0, hw_req = 1'b0;
  logic        cancel = 1'b0, done_clr = 1'b0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;
  logic        busy, done, irq_major, irq_err, link_req;
  logic [3:0]  link_ch;
  logic [7:0]  major_left;
  logic [15:0] cur_src, cur_dst;

  logic [31:0] mem [256];
  logic        mem_init = 1'b0;
  logic [15:0] err_addr = 16'hFFFF;
  int          link_cnt = 0;
  logic [3:0]  last_link_ch = '0;
  int          n_chk = 0, n_pass = 0;

  always #10 clk = ~clk;

  nlx_dma_engine dut_i (.*);

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  function automatic int widx(input int a);
    return (a >> 2) & 255;
  endfunction

  // Memory model: answers every other cycle, one response per request.
  always @(negedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_rvalid <= 1'b0;
      mem_err    <= 1'b0;
    end else if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_err    <= (mem_addr == err_addr);
      if (mem_addr != err_addr) begin
        if (mem_we) mem[widx(int'(mem_addr))] <= mem_wdata;
        else mem_rdata <= mem[widx(int'(mem_addr))];
      end
    end else begin
      mem_rvalid <= 1'b0;
      mem_err    <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (link_req) begin
      link_cnt     <= link_cnt + 1;
      last_link_ch <= link_ch;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic init_mem();
    mem_init = 1'b1;
    @(negedge clk);
    mem_init = 1'b0;
  endtask

  task automatic load(input int src, input int dst, input int soff, input int doff,
                      input int nb, input int maj, input bit ie, input bit ee,
                      input bit le, input int lch);
    cfg_src = 16'(src); cfg_dst = 16'(dst);
    cfg_soff = 16'(soff); cfg_doff = 16'(doff);
    cfg_nbytes = 8'(nb); cfg_major = 8'(maj);
    cfg_int_en = ie; cfg_err_en = ee; cfg_link_en = le; cfg_link_ch = 4'(lch);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_act(input int kind);
    if (kind == 0) sw_start = 1'b1;
    else if (kind == 1) link_in = 1'b1;
    else hw_req = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; link_in = 1'b0; hw_req = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_pass, n_chk + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] exp_m [256];
    int w, src0, dst0, soff, doff, nb, maj, idx, l0, mism, n, ml;
    bit ie, le;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !mem_req, "R10", "idle after reset", int'(busy), 0);
    chk(!done && !irq_major && !irq_err && !link_req, "R10", "flags clear",
        int'({done, irq_major, irq_err, link_req}), 0);
    chk(major_left == 0 && cur_src == 0 && cur_dst == 0, "R10", "counters zero",
        int'(major_left), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep over steps, sizes, counts and activation sources.
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++)
          for (int d = 0; d < 2; d++) begin
            idx  = a * 12 + b * 4 + c * 2 + d;
            soff = a ? -4 : 4;
            doff = (b == 0) ? 4 : ((b == 1) ? -8 : 0);
            nb   = c ? 12 : 2;
            w    = c ? 3 : 1;
            maj  = d ? 3 : 1;
            ie   = a[0] ^ c[0];
            le   = (idx % 3) != 2;
            src0 = (soff > 0) ? 16'h040 : 16'h1C0;
            dst0 = (doff >= 0) ? 16'h240 : 16'h3C0;
            init_mem();
            load(src0, dst0, soff, doff, nb, maj, ie, 1'b0, le, idx % 16);
            chk(cur_src == 16'(src0) && major_left == 8'(maj) && !done, "R1",
                "descriptor latched", int'(major_left), maj);
            l0 = link_cnt;
            for (int i = 0; i < maj; i++) begin
              chk(major_left == 8'(maj - i), "R5", "count before loop",
                  int'(major_left), maj - i);
              pulse_act((idx + i) % 3);
              wait_idle();
            end
            @(negedge clk);
            chk(major_left == 0, "R5", "count exhausted", int'(major_left), 0);
            chk(done == 1'b1, "R7", "done set", int'(done), 1);
            chk(irq_major == ie, "R7", "irq follows enable", int'(irq_major), int'(ie));
            chk(link_cnt - l0 == (le ? maj - 1 : 0), "R6", "link pulse count",
                link_cnt - l0, le ? maj - 1 : 0);
            if (le && maj > 1)
              chk(last_link_ch == 4'(idx % 16), "R6", "link channel",
                  int'(last_link_ch), idx % 16);
            chk(cur_src == 16'(src0 + maj * w * soff), "R4", "final source",
                int'(cur_src), (src0 + maj * w * soff) & 16'hFFFF);
            chk(cur_dst == 16'(dst0 + maj * w * doff), "R4", "final destination",
                int'(cur_dst), (dst0 + maj * w * doff) & 16'hFFFF);
            for (int i = 0; i < 256; i++) exp_m[i] = pat(i);
            for (int k = 0; k < maj * w; k++)
              exp_m[widx(dst0 + k * doff)] = pat(widx(src0 + k * soff));
            mism = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) mism++;
            chk(mism == 0, (c ? "R3" : "R5"), "memory image mismatches", mism, 0);
            if (idx == 0) begin
              pulse_act(0);
              chk(!busy && !mem_req, "R2", "start with zero count ignored",
                  int'(busy), 0);
              done_clr = 1'b1;
              @(negedge clk);
              done_clr = 1'b0;
              chk(!done && !irq_major, "R7", "done_clr clears", int'(done), 0);
            end
          end

    // Activation and load while busy are ignored.
    init_mem();
    load(16'h040, 16'h240, 4, 4, 16, 3, 1'b0, 1'b0, 1'b0, 0);
    pulse_act(0);
    hw_req = 1'b1; cfg_load = 1'b1; cfg_src = 16'h100; cfg_major = 8'd9;
    @(negedge clk);
    hw_req = 1'b0; cfg_load = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(major_left == 2, "R2", "extra activation while busy ignored",
        int'(major_left), 2);
    chk(cur_src == 16'h050, "R1", "load while busy ignored", int'(cur_src), 16'h050);

    // Load and activation in the same cycle: load wins.
    sw_start = 1'b1;
    load(16'h080, 16'h280, 4, 4, 4, 2, 1'b0, 1'b0, 1'b0, 0);
    sw_start = 1'b0;
    chk(!busy && major_left == 2 && cur_src == 16'h080, "R1",
        "load beats activation", int'(busy), 0);

    // Cancel in the middle of an inner loop.
    load(16'h040, 16'h240, 4, 8, 16, 2, 1'b0, 1'b0, 1'b0, 0);
    pulse_act(1);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R8", "busy before cancel", int'(busy), 1);
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
    chk(!busy && !mem_req, "R8", "stopped after cancel", int'(mem_req), 0);
    chk(major_left == 2, "R8", "count kept on cancel", int'(major_left), 2);
    n = (int'(cur_src) - 16'h040) / 4;
    chk(n >= 0 && n < 4 && cur_dst == 16'(16'h240 + 8 * n), "R8",
        "addresses consistent after cancel", int'(cur_dst), 16'h240 + 8 * n);
    ml = 0;
    repeat (4) begin
      @(negedge clk);
      if (mem_req) ml++;
    end
    chk(ml == 0, "R8", "no requests after cancel", ml, 0);
    pulse_act(2);
    wait_idle();
    chk(major_left == 1 && cur_src == 16'(16'h040 + 4 * (n + 4)), "R4",
        "resume from kept address", int'(cur_src), 16'h040 + 4 * (n + 4));

    // Error on the second read, with error reporting enabled.
    init_mem();
    err_addr = 16'h044;
    load(16'h040, 16'h240, 4, 4, 16, 2, 1'b1, 1'b1, 1'b1, 3);
    pulse_act(0);
    wait_idle();
    chk(irq_err == 1'b1, "R9", "error interrupt", int'(irq_err), 1);
    chk(major_left == 2 && !done, "R9", "count kept on error", int'(major_left), 2);
    chk(cur_src == 16'h044, "R9", "address not advanced past error",
        int'(cur_src), 16'h044);
    pulse_act(0);
    chk(!busy, "R9", "activation ignored when halted", int'(busy), 0);
    err_addr = 16'hFFFF;
    load(16'h040, 16'h240, 4, 4, 16, 2, 1'b1, 1'b0, 1'b0, 0);
    chk(!irq_err, "R1", "load clears error", int'(irq_err), 0);

    // Error on a write, with error reporting disabled.
    err_addr = 16'h240;
    pulse_act(1);
    wait_idle();
    chk(!irq_err && major_left == 2, "R9", "silent error halts",
        int'(irq_err), 0);
    pulse_act(2);
    chk(!busy, "R9", "silent halt ignores activation", int'(busy), 0);
    err_addr = 16'hFFFF;

    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

endmodule